// File: doc/BRIEF.md
# Operate Microinstruction Execution Unit

This unit executes one operate-class instruction word of a 12-bit minicomputer against the accumulator (AC) and the one-bit link. A single instruction word can select several independent microoperations through separate bits, and the unit applies them in a fixed sub-step order. It returns the new AC and link values, a request to skip the next instruction, and a request to halt.

The surrounding core presents the instruction, the current AC and link, and the front-panel switch word, with a valid strobe. One clock later the unit returns registered results with a matching valid strobe. Instructions that are not operate-class, and operate words of the third group, pass the AC and link through unchanged. The data width and support for the double-rotate encoding are parameters.

Bit numbers below count the 12-bit instruction as a vector, with index 11 as the most significant bit. An operate word has `instr_i[11:9]` = 3'b111.

Top module: `opr_micro_unit`

## Requirements
- R1: While `rst_n` is low and after reset, `valid_o`, `skip_o`, `halt_o`, `link_o` and `ac_o` are all zero.
- R2: `valid_o` equals `valid_i` from the previous cycle. Results appear one cycle after the word is accepted. `skip_o` and `halt_o` are low whenever `valid_o` is low.
- R3: A word with `instr_i[11:9]` != 3'b111, or a third-group word (`instr_i[8]` and `instr_i[0]` both set), returns AC and link unchanged, with no skip and no halt.
- R4: In group 1 (operate word, `instr_i[8]` clear), index 7 clears AC and index 6 clears the link. These clears are the first sub-step.
- R5: In group 1, index 5 inverts AC and index 4 inverts the link. Both act after the clears.
- R6: In group 1, index 0 adds one to the 13-bit value {link, AC} after the inversions, so a carry out of AC toggles the link.
- R7: In group 1, index 2 rotates {link, AC} one place left (AC MSB into the link, link into AC LSB). Index 3 rotates one place right. Either rotate acts after the increment. Index 1 makes the rotate two places. Indices 2 and 3 together leave the value unrotated. Index 1 without a rotate has no effect.
- R8: A group-1 word never raises `skip_o` or `halt_o`.
- R9: In group 2 (`instr_i[8]` set, `instr_i[0]` clear), the skip test uses the incoming values. The conditions are: index 6 tests AC MSB set, index 5 tests AC zero, and index 4 tests link set. If index 3 is clear, the unit skips when any selected condition holds. If index 3 is set, it skips only when none holds, so with nothing selected the skip is unconditional.
- R10: In group 2, index 7 clears AC, and then index 2 ORs `sr_i` into AC. The link is unchanged.
- R11: A group-2 word with index 1 set raises `halt_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Instruction word and operands are present |
| instr_i | input | 12 | Instruction word |
| ac_i | input | DATA_W | Current accumulator |
| link_i | input | 1 | Current link bit |
| sr_i | input | DATA_W | Front-panel switch word |
| valid_o | output | 1 | Results are valid |
| ac_o | output | DATA_W | New accumulator |
| link_o | output | 1 | New link bit |
| skip_o | output | 1 | Skip-next-instruction request |
| halt_o | output | 1 | Halt request |

## Verification
The hardest cases to reach from the ports are those where sub-steps interact: an increment whose carry toggles the link just before a double rotate moves that link back into AC, and an inverted skip test with no condition selected. A sweep over a handful of operand cases alone would rarely hit these. The bench therefore applies all 4096 instruction words against eight operand sets. These sets include all-ones and all-zero AC, a lone MSB, and both link values. Every word, including the carry and double-rotate combinations, is checked against an arithmetic model. Hand-worked words confirm the increment-before-rotate order, the clear-before-invert order, and the negation idiom.

// File: rtl/opr_pkg.sv
package opr_pkg;
   localparam int INSTR_W = 12;

   // group 1 field positions
   localparam int G1_CLA = 7;
   localparam int G1_CLL = 6;
   localparam int G1_CMA = 5;
   localparam int G1_CML = 4;
   localparam int G1_RAR = 3;
   localparam int G1_RAL = 2;
   localparam int G1_DBL = 1;
   localparam int G1_IAC = 0;

   // group 2 field positions
   localparam int G2_CLA = 7;
   localparam int G2_NEG = 6;
   localparam int G2_ZER = 5;
   localparam int G2_LNK = 4;
   localparam int G2_INV = 3;
   localparam int G2_OSR = 2;
   localparam int G2_HLT = 1;

   typedef enum logic [1:0] {
      CLS_PASS = 2'd0,
      CLS_G1   = 2'd1,
      CLS_G2   = 2'd2
   } opr_cls_e;

   function automatic opr_cls_e opr_classify(input logic [INSTR_W-1:0] w);
      if (w[11:9] != 3'b111) return CLS_PASS;
      if (!w[8])             return CLS_G1;
      if (!w[0])             return CLS_G2;
      return CLS_PASS;
   endfunction
endpackage

// File: rtl/opr_rotate.sv
module opr_rotate #(
   parameter int DATA_W = 12,
   parameter bit DBL_EN = 1'b1
) (
   input  logic [DATA_W:0] ring_i,
   input  logic            rol_i,
   input  logic            ror_i,
   input  logic            dbl_i,
   output logic [DATA_W:0] ring_o
);
   localparam int STAGES = 2;

   logic [DATA_W:0] st [0:STAGES];
   assign st[0] = ring_i;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0 || DBL_EN) begin : g_live
         logic act;
         assign act = (s == 0) ? 1'b1 : dbl_i;
         always_comb begin
            st[s+1] = st[s];
            if (act && rol_i && !ror_i)
               st[s+1] = {st[s][DATA_W-1:0], st[s][DATA_W]};
            else if (act && ror_i && !rol_i)
               st[s+1] = {st[s][0], st[s][DATA_W:1]};
         end
      end else begin : g_thru
         assign st[s+1] = st[s];
      end
   end

   assign ring_o = st[STAGES];
endmodule

// File: rtl/opr_group1.sv
module opr_group1 import opr_pkg::*; #(
   parameter int DATA_W = 12,
   parameter bit DBL_EN = 1'b1
) (
   input  logic [INSTR_W-1:0] instr_i,
   input  logic [DATA_W-1:0]  ac_i,
   input  logic               link_i,
   output logic [DATA_W-1:0]  ac_o,
   output logic               link_o
);
   logic [DATA_W:0] pre_rot;
   logic [DATA_W:0] post_rot;

   always_comb begin
      logic [DATA_W-1:0] a;
      logic              l;
      a = instr_i[G1_CLA] ? '0 : ac_i;
      l = instr_i[G1_CLL] ? 1'b0 : link_i;
      if (instr_i[G1_CMA]) a = ~a;
      if (instr_i[G1_CML]) l = ~l;
      pre_rot = {l, a};
      if (instr_i[G1_IAC]) pre_rot = pre_rot + 1'b1;
   end

   opr_rotate #(.DATA_W(DATA_W), .DBL_EN(DBL_EN)) u_rot (
      .ring_i (pre_rot),
      .rol_i  (instr_i[G1_RAL]),
      .ror_i  (instr_i[G1_RAR]),
      .dbl_i  (instr_i[G1_DBL]),
      .ring_o (post_rot)
   );

   assign link_o = post_rot[DATA_W];
   assign ac_o   = post_rot[DATA_W-1:0];
endmodule

// File: rtl/opr_group2.sv
module opr_group2 import opr_pkg::*; #(
   parameter int DATA_W = 12
) (
   input  logic [INSTR_W-1:0] instr_i,
   input  logic [DATA_W-1:0]  ac_i,
   input  logic               link_i,
   input  logic [DATA_W-1:0]  sr_i,
   output logic [DATA_W-1:0]  ac_o,
   output logic               skip_o,
   output logic               halt_o
);
   logic hit;

   assign hit = (instr_i[G2_NEG] &&  ac_i[DATA_W-1])
             || (instr_i[G2_ZER] && (ac_i == '0))
             || (instr_i[G2_LNK] &&  link_i);

   assign skip_o = instr_i[G2_INV] ? !hit : hit;

   always_comb begin
      ac_o = instr_i[G2_CLA] ? '0 : ac_i;
      if (instr_i[G2_OSR]) ac_o = ac_o | sr_i;
   end

   assign halt_o = instr_i[G2_HLT];
endmodule

// File: rtl/opr_micro_unit.sv
module opr_micro_unit import opr_pkg::*; #(
   parameter int DATA_W = 12,
   parameter bit DBL_EN = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                valid_i,
   input  logic [INSTR_W-1:0]  instr_i,
   input  logic [DATA_W-1:0]   ac_i,
   input  logic                link_i,
   input  logic [DATA_W-1:0]   sr_i,
   output logic                valid_o,
   output logic [DATA_W-1:0]   ac_o,
   output logic                link_o,
   output logic                skip_o,
   output logic                halt_o
);
   if (DATA_W < 2) begin : g_bad_width
      $error("opr_micro_unit: DATA_W must be at least 2");
   end

   opr_cls_e          cls;
   logic [DATA_W-1:0] g1_ac, g2_ac, nxt_ac;
   logic              g1_link, g2_skip, g2_halt;
   logic              nxt_link, nxt_skip, nxt_halt;

   assign cls = opr_classify(instr_i);

   opr_group1 #(.DATA_W(DATA_W), .DBL_EN(DBL_EN)) u_g1 (
      .instr_i (instr_i),
      .ac_i    (ac_i),
      .link_i  (link_i),
      .ac_o    (g1_ac),
      .link_o  (g1_link)
   );

   opr_group2 #(.DATA_W(DATA_W)) u_g2 (
      .instr_i (instr_i),
      .ac_i    (ac_i),
      .link_i  (link_i),
      .sr_i    (sr_i),
      .ac_o    (g2_ac),
      .skip_o  (g2_skip),
      .halt_o  (g2_halt)
   );

   always_comb begin
      nxt_ac   = ac_i;
      nxt_link = link_i;
      nxt_skip = 1'b0;
      nxt_halt = 1'b0;
      case (cls)
         CLS_G1: begin
            nxt_ac   = g1_ac;
            nxt_link = g1_link;
         end
         CLS_G2: begin
            nxt_ac   = g2_ac;
            nxt_skip = g2_skip;
            nxt_halt = g2_halt;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_o <= 1'b0;
         ac_o    <= '0;
         link_o  <= 1'b0;
         skip_o  <= 1'b0;
         halt_o  <= 1'b0;
      end else begin
         valid_o <= valid_i;
         skip_o  <= valid_i && nxt_skip;
         halt_o  <= valid_i && nxt_halt;
         if (valid_i) begin
            ac_o   <= nxt_ac;
            link_o <= nxt_link;
         end
      end
   end

   // checks on the registered results
   logic in_g1, in_g2;
   assign in_g1 = (instr_i[11:9] == 3'b111) && !instr_i[8];
   assign in_g2 = (instr_i[11:9] == 3'b111) && instr_i[8] && !instr_i[0];

   p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      valid_i |=> valid_o);
   p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_o |-> (!skip_o && !halt_o));
   p_pass_through_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && !in_g1 && !in_g2) |=>
         (ac_o == $past(ac_i) && link_o == $past(link_i) && !skip_o && !halt_o));
   p_clear_both_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && in_g1 && instr_i[7:0] == 8'b1100_0000) |=>
         (ac_o == '0 && !link_o));
   p_g1_no_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && in_g1) |=> (!skip_o && !halt_o));
   p_always_skip_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && in_g2 && instr_i[6:3] == 4'b0001) |=> skip_o);
   p_g2_link_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && in_g2) |=> (link_o == $past(link_i)));
   p_halt_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && in_g2 && instr_i[1]) |=> halt_o);
endmodule

// File: tb/opr_micro_unit_test.sv
module opr_micro_unit_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        valid_i = 1'b0;
   logic [11:0] instr_i = '0;
   logic [11:0] ac_i = '0;
   logic        link_i = 1'b0;
   logic [11:0] sr_i = '0;
   logic        valid_o, link_o, skip_o, halt_o;
   logic [11:0] ac_o;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   opr_micro_unit uut (
      .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .instr_i(instr_i),
      .ac_i(ac_i), .link_i(link_i), .sr_i(sr_i), .valid_o(valid_o),
      .ac_o(ac_o), .link_o(link_o), .skip_o(skip_o), .halt_o(halt_o)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s instr=%o act=%0h exp=%0h", tag, instr_i, act, exp);
      end
   endtask

   // model built from the requirements
   task automatic model(input logic [11:0] i, input logic [11:0] a, input logic l,
                        input logic [11:0] s, output logic [11:0] ea, output logic el,
                        output logic es, output logic eh);
      int tmp;
      ea = a; el = l; es = 1'b0; eh = 1'b0;
      if (i[11:9] == 3'b111 && !i[8]) begin
         tmp = {19'd0, l, a};
         if (i[7]) tmp = tmp & 32'h1000;
         if (i[6]) tmp = tmp & 32'h0FFF;
         if (i[5]) tmp = tmp ^ 32'h0FFF;
         if (i[4]) tmp = tmp ^ 32'h1000;
         if (i[0]) tmp = (tmp + 1) % 8192;
         if (i[2] != i[3]) begin
            for (int k = 0; k < (i[1] ? 2 : 1); k++) begin
               if (i[2]) tmp = ((tmp * 2) % 8192) + (tmp / 4096);
               else      tmp = (tmp / 2) + ((tmp % 2) * 4096);
            end
         end
         ea = tmp[11:0]; el = tmp[12];
      end else if (i[11:9] == 3'b111 && !i[0]) begin
         logic any;
         any = (i[6] && a >= 12'd2048) || (i[5] && a == 0) || (i[4] && l);
         es = i[3] ? !any : any;
         ea = (i[7] ? 12'd0 : a) | (i[2] ? s : 12'd0);
         eh = i[1];
      end
   endtask

   task automatic apply(input logic [11:0] i, input logic [11:0] a, input logic l,
                        input logic [11:0] s);
      instr_i = i; ac_i = a; link_i = l; sr_i = s; valid_i = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      logic [11:0] ea;
      logic el, es, eh;
      logic [11:0] pat [8];
      pat = '{12'o0000, 12'o7777, 12'o4000, 12'o0001, 12'o3777, 12'o5252, 12'o2525, 12'o1234};

      repeat (3) @(negedge clk);
      chk("R1 valid", valid_o, 0);
      chk("R1 ac", ac_o, 0);
      chk("R1 link", link_o, 0);
      chk("R1 skip", skip_o, 0);
      chk("R1 halt", halt_o, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 idle after reset", {valid_o, skip_o, halt_o}, 0);

      // hand-worked words
      apply(12'o7005, 12'o7777, 1'b0, 12'o0);
      chk("R6 R7 inc then rotate ac", ac_o, 12'o0001);
      chk("R6 R7 inc then rotate link", link_o, 0);
      apply(12'o7224, 12'o5555, 1'b0, 12'o0);
      chk("R4 R5 R7 clear invert rotate ac", ac_o, 12'o0001);
      chk("R4 R5 R7 clear invert rotate link", link_o, 0);
      apply(12'o7041, 12'o0005, 1'b0, 12'o0);
      chk("R5 R6 negate", ac_o, 12'o7773);
      apply(12'o7550, 12'o0000, 1'b0, 12'o0);
      chk("R9 inverted test zero ac", skip_o, 0);
      apply(12'o7550, 12'o0001, 1'b0, 12'o0);
      chk("R9 inverted test positive ac", skip_o, 1);
      apply(12'o7404, 12'o0100, 1'b1, 12'o1057);
      chk("R10 switch or", ac_o, 12'o1157);
      apply(12'o7402, 12'o0000, 1'b0, 12'o0);
      chk("R11 halt", halt_o, 1);

      // sweep every word over eight operand sets
      for (int p = 0; p < 8; p++) begin
         for (int w = 0; w < 4096; w++) begin
            logic [11:0] i;
            logic [11:0] s;
            string tg;
            i = w[11:0];
            s = 12'o1057 ^ (p[11:0] * 12'o0101);
            apply(i, pat[p], p[0], s);
            model(i, pat[p], p[0], s, ea, el, es, eh);
            chk("R2 valid", valid_o, 1);
            if (i[11:9] != 3'b111 || (i[8] && i[0])) begin
               chk("R3 ac", ac_o, ea);
               chk("R3 link", link_o, el);
               chk("R3 req", {skip_o, halt_o}, 0);
            end else if (!i[8]) begin
               if (i[3] || i[2])      tg = "R7";
               else if (i[0])         tg = "R6";
               else if (i[5] || i[4]) tg = "R5";
               else                   tg = "R4";
               chk(tg, {link_o, ac_o}, {el, ea});
               chk("R8 req", {skip_o, halt_o}, 0);
            end else begin
               chk("R9 skip", skip_o, es);
               chk("R10 ac", ac_o, ea);
               chk("R10 link", link_o, el);
               chk("R11 halt", halt_o, eh);
            end
            if (w % 512 == 511) begin
               valid_i = 1'b0;
               instr_i = 12'o7402;
               @(negedge clk);
               chk("R2 idle", {valid_o, skip_o, halt_o}, 0);
            end
         end
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog act=timeout exp=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule